// File: doc/BRIEF.md
# PS/2 Wake Event and Isolation Controller

This block sits between the keyboard and mouse PS/2 pins and an internal keyboard controller core. It can cut the clock and data lines going into the core while the wake detector keeps watching the data lines. It shapes the two interrupt lines coming back from the core, either as a latched form or as the live line ANDed with its latched copy. It also gathers four power-management wake sources into sticky status bits that drive a single wake output through per-source enables and one global enable.

Firmware sets up isolation before a sleep state. The wake logic then records a falling edge on either data line on any power rail. A rising edge of a controller interrupt is recorded only while main power is present. A separate global configuration register carries a core reset bit that software sets and clears explicitly.

Top module: `ps2_wake_iso`

## Requirements
- R1: Control register bit 5 isolates the keyboard: while it is 1, core_kbd_clk and core_kbd_dat are held at 1 (idle). While it is 0, they follow kbd_clk_pin and kbd_dat_pin without delay.
- R2: Control register bit 6 isolates the mouse in the same way for core_ms_clk and core_ms_dat. The control register reads back on ctrl_rd with bits 6..3 as written and all other bits 0.
- R3: Isolation never blocks the wake path. A falling edge on an isolated data pin still sets its status bit.
- R4: When a latch-mode bit is 0 (bit 3 for the keyboard, bit 4 for the mouse), the interrupt output equals the live core interrupt AND its latch.
- R5: When a latch-mode bit is 1, the interrupt output equals the latch alone. The latch is set on a rising core interrupt, one cycle after the edge, and cleared by the matching clear strobe.
- R6: pme_sts bit 0 is set by a rising core_kint, bit 1 by a rising core_mint, bit 2 by a falling kbd_dat_pin and bit 3 by a falling ms_dat_pin. The data pins pass through a two-flop synchronizer before edge detection.
- R7: While main_pwr is 0, the interrupt sources (bits 0 and 1) are ignored and the data-edge sources (bits 2 and 3) still set status.
- R8: Status bits are sticky whatever the enables are. A write with sts_clr_wr clears exactly the bits that are 1 in sts_clr_data.
- R9: pme_out is 1 exactly when the global enable is 1 and some status bit has its wake-enable bit set.
- R10: gcr_wr_data bit 6 is the core reset. Writing 0x40 asserts core_rst and writing 0x00 releases it. It never clears by itself.
- R11: After reset, ctrl_rd, pme_sts, core_rst, pme_out, kint_out and mint_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| main_pwr | input | 1 | 1 = main rail present, 0 = standby only |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| ctrl_rd | output | 8 | Control register readback |
| gcr_wr_en | input | 1 | Global config register write strobe |
| gcr_wr_data | input | 8 | Global config write data (bit 6 = core reset) |
| core_rst | output | 1 | Reset to the controller core |
| en_wr | input | 1 | Wake-enable write strobe |
| en_wr_data | input | 4 | Wake-enable bits, same order as pme_sts |
| gpme_wr | input | 1 | Global enable write strobe |
| gpme_wr_data | input | 1 | Global enable value |
| sts_clr_wr | input | 1 | Status write-one-to-clear strobe |
| sts_clr_data | input | 4 | Status bits to clear |
| pme_sts | output | 4 | Sticky wake status |
| pme_out | output | 1 | Wake event output |
| kbd_clk_pin | input | 1 | Keyboard clock pin |
| kbd_dat_pin | input | 1 | Keyboard data pin |
| ms_clk_pin | input | 1 | Mouse clock pin |
| ms_dat_pin | input | 1 | Mouse data pin |
| core_kbd_clk | output | 1 | Keyboard clock to core |
| core_kbd_dat | output | 1 | Keyboard data to core |
| core_ms_clk | output | 1 | Mouse clock to core |
| core_ms_dat | output | 1 | Mouse data to core |
| core_kint | input | 1 | Keyboard interrupt from core |
| core_mint | input | 1 | Mouse interrupt from core |
| kint_clr | input | 1 | Keyboard latch clear (host read of output port) |
| mint_clr | input | 1 | Mouse latch clear |
| kint_out | output | 1 | Shaped keyboard interrupt |
| mint_out | output | 1 | Shaped mouse interrupt |

## Verification
The assertions check every cycle that isolated core lines stay idle, that a mode-0 interrupt output never exceeds its live line, and that a cleared latch drops its output. They also check that the standby rail blocks interrupt status, that status bits survive any cycle with no clear, that the wake output stays consistent with status, enables and global enable, and that the core reset holds between writes. Only the bench scenarios can show the positive effects. These are that each source lands in its own status bit after the synchronizer delay, that data edges are still recorded through isolation and on standby power, that a mode-1 output outlives its live line, and that each clear mask removes exactly its bits.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;

    localparam int NSRC = 4;

    // status / enable bit positions
    localparam int SRC_KINT = 0;
    localparam int SRC_MINT = 1;
    localparam int SRC_KDAT = 2;
    localparam int SRC_MDAT = 3;

    // sources honoured only on main power
    localparam logic [NSRC-1:0] MAIN_ONLY_MASK = 4'b0011;

    // control register bit positions
    localparam int CB_MISO = 6;
    localparam int CB_KISO = 5;
    localparam int CB_MLAT = 4;
    localparam int CB_KLAT = 3;

    // global configuration register core-reset bit
    localparam int GCR_RST_BIT = 6;

    typedef struct packed {
        logic m_iso;
        logic k_iso;
        logic m_latmode;
        logic k_latmode;
    } ctrl_t;

    typedef struct packed {
        ctrl_t      ctrl;
        logic       core_rst;
        logic [1:0] dat_prev;
    } top_st_t;

    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic [NSRC-1:0] en;
        logic            gpme;
    } wake_st_t;

    typedef struct packed {
        logic prev;
        logic latched;
    } irq_st_t;

endpackage

// File: rtl/ps2w_sync.sv
module ps2w_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= {WIDTH{RST_VAL}};
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ps2w_irq_latch.sv
module ps2w_irq_latch
    import ps2w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic clr,
    input  logic lat_mode,
    output logic irq_out,
    output logic irq_rise
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        irq_rise  = irq_in & ~st_q.prev;
        st_d.prev = irq_in;
        if (irq_rise)  st_d.latched = 1'b1;
        else if (clr)  st_d.latched = 1'b0;
        irq_out = lat_mode ? st_q.latched : (irq_in & st_q.latched);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ps2w_wake.sv
module ps2w_wake
    import ps2w_pkg::*;
#(
    parameter int N = NSRC,
    parameter logic [N-1:0] MAIN_MASK = MAIN_ONLY_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         main_pwr,
    input  logic [N-1:0] evt,
    input  logic         en_wr,
    input  logic [N-1:0] en_wr_data,
    input  logic         gpme_wr,
    input  logic         gpme_wr_data,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] sts,
    output logic [N-1:0] en,
    output logic         gpme,
    output logic         pme
);
    logic [N-1:0] sts_d, sts_q, en_d, en_q, qual;
    logic         gpme_d, gpme_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_qual
            if (MAIN_MASK[g]) begin : g_main
                assign qual[g] = evt[g] & main_pwr;
            end else begin : g_any
                assign qual[g] = evt[g];
            end
        end
    endgenerate

    always_comb begin
        sts_d  = sts_q;
        en_d   = en_q;
        gpme_d = gpme_q;
        if (clr_wr)  sts_d = sts_d & ~clr_data;
        sts_d = sts_d | qual;
        if (en_wr)   en_d   = en_wr_data;
        if (gpme_wr) gpme_d = gpme_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= '0;
            en_q   <= '0;
            gpme_q <= 1'b0;
        end else begin
            sts_q  <= sts_d;
            en_q   <= en_d;
            gpme_q <= gpme_d;
        end
    end

    assign sts  = sts_q;
    assign en   = en_q;
    assign gpme = gpme_q;
    assign pme  = gpme_q & (|(sts_q & en_q));
endmodule

// File: rtl/ps2_wake_iso.sv
module ps2_wake_iso
    import ps2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_pwr,
    input  logic       cfg_wr_en,
    input  logic [7:0] cfg_wr_data,
    output logic [7:0] ctrl_rd,
    input  logic       gcr_wr_en,
    input  logic [7:0] gcr_wr_data,
    output logic       core_rst,
    input  logic       en_wr,
    input  logic [3:0] en_wr_data,
    input  logic       gpme_wr,
    input  logic       gpme_wr_data,
    input  logic       sts_clr_wr,
    input  logic [3:0] sts_clr_data,
    output logic [3:0] pme_sts,
    output logic       pme_out,
    input  logic       kbd_clk_pin,
    input  logic       kbd_dat_pin,
    input  logic       ms_clk_pin,
    input  logic       ms_dat_pin,
    output logic       core_kbd_clk,
    output logic       core_kbd_dat,
    output logic       core_ms_clk,
    output logic       core_ms_dat,
    input  logic       core_kint,
    input  logic       core_mint,
    input  logic       kint_clr,
    input  logic       mint_clr,
    output logic       kint_out,
    output logic       mint_out
);
    top_st_t    st_d, st_q;
    logic [1:0] dat_s;
    logic [1:0] dat_fall;
    logic       kint_rise, mint_rise;
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] wake_en_w;
    logic            gpme_w;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{cfg_wr_data[7], cfg_wr_data[2:0],
                              gcr_wr_data[7], gcr_wr_data[5:0]};

    // data lines into the wake detector, never gated
    ps2w_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ms_dat_pin, kbd_dat_pin}),
        .dout  (dat_s)
    );

    always_comb begin
        st_d          = st_q;
        st_d.dat_prev = dat_s;
        dat_fall      = st_q.dat_prev & ~dat_s;
        if (cfg_wr_en) begin
            st_d.ctrl.m_iso     = cfg_wr_data[CB_MISO];
            st_d.ctrl.k_iso     = cfg_wr_data[CB_KISO];
            st_d.ctrl.m_latmode = cfg_wr_data[CB_MLAT];
            st_d.ctrl.k_latmode = cfg_wr_data[CB_KLAT];
        end
        if (gcr_wr_en) st_d.core_rst = gcr_wr_data[GCR_RST_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dat_prev <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[CB_MISO]     = st_q.ctrl.m_iso;
        ctrl_rd[CB_KISO]     = st_q.ctrl.k_iso;
        ctrl_rd[CB_MLAT]     = st_q.ctrl.m_latmode;
        ctrl_rd[CB_KLAT]     = st_q.ctrl.k_latmode;
    end

    // isolation: blocked lines rest at the PS/2 idle level
    assign core_kbd_clk = st_q.ctrl.k_iso | kbd_clk_pin;
    assign core_kbd_dat = st_q.ctrl.k_iso | kbd_dat_pin;
    assign core_ms_clk  = st_q.ctrl.m_iso | ms_clk_pin;
    assign core_ms_dat  = st_q.ctrl.m_iso | ms_dat_pin;
    assign core_rst     = st_q.core_rst;

    ps2w_irq_latch u_klat (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (core_kint),
        .clr      (kint_clr),
        .lat_mode (st_q.ctrl.k_latmode),
        .irq_out  (kint_out),
        .irq_rise (kint_rise)
    );

    ps2w_irq_latch u_mlat (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (core_mint),
        .clr      (mint_clr),
        .lat_mode (st_q.ctrl.m_latmode),
        .irq_out  (mint_out),
        .irq_rise (mint_rise)
    );

    always_comb begin
        evt           = '0;
        evt[SRC_KINT] = kint_rise;
        evt[SRC_MINT] = mint_rise;
        evt[SRC_KDAT] = dat_fall[0];
        evt[SRC_MDAT] = dat_fall[1];
    end

    ps2w_wake #(.N(NSRC), .MAIN_MASK(MAIN_ONLY_MASK)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_pwr     (main_pwr),
        .evt          (evt),
        .en_wr        (en_wr),
        .en_wr_data   (en_wr_data),
        .gpme_wr      (gpme_wr),
        .gpme_wr_data (gpme_wr_data),
        .clr_wr       (sts_clr_wr),
        .clr_data     (sts_clr_data),
        .sts          (pme_sts),
        .en           (wake_en_w),
        .gpme         (gpme_w),
        .pme          (pme_out)
    );
endmodule

// File: rtl/ps2w_chk.sv
module ps2w_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       main_pwr,
    input logic [7:0] ctrl_rd,
    input logic       gcr_wr_en,
    input logic [7:0] gcr_wr_data,
    input logic       core_rst,
    input logic       sts_clr_wr,
    input logic [3:0] sts_clr_data,
    input logic [3:0] pme_sts,
    input logic [3:0] wake_en,
    input logic       gpme,
    input logic       pme_out,
    input logic       core_kbd_clk,
    input logic       core_kbd_dat,
    input logic       core_ms_clk,
    input logic       core_ms_dat,
    input logic       core_kint,
    input logic       core_mint,
    input logic       kint_clr,
    input logic       kint_out,
    input logic       mint_out
);
    logic [3:0] keep_mask;
    assign keep_mask = sts_clr_wr ? ~sts_clr_data : 4'hF;

    p_kiso_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[5] |-> (core_kbd_clk && core_kbd_dat));

    p_miso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[6] |-> (core_ms_clk && core_ms_dat));

    p_kand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[3] && kint_out) |-> core_kint);

    p_mand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[4] && mint_out) |-> core_mint);

    p_kclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kint_clr && !core_kint) |=> !kint_out);

    p_stdby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr |=> !($rose(pme_sts[0]) || $rose(pme_sts[1])));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pme_sts & $past(pme_sts & keep_mask)) == $past(pme_sts & keep_mask)));

    p_pme_need_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pme_out |-> (gpme && ((pme_sts & wake_en) != 4'h0)));

    p_pme_give_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gpme && ((pme_sts & wake_en) != 4'h0)) |-> pme_out);

    p_rst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && !gcr_wr_en) |=> core_rst);

    p_rst_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gcr_wr_en && gcr_wr_data == 8'h40) |=> core_rst);
endmodule

bind ps2_wake_iso ps2w_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_pwr     (main_pwr),
    .ctrl_rd      (ctrl_rd),
    .gcr_wr_en    (gcr_wr_en),
    .gcr_wr_data  (gcr_wr_data),
    .core_rst     (core_rst),
    .sts_clr_wr   (sts_clr_wr),
    .sts_clr_data (sts_clr_data),
    .pme_sts      (pme_sts),
    .wake_en      (wake_en_w),
    .gpme         (gpme_w),
    .pme_out      (pme_out),
    .core_kbd_clk (core_kbd_clk),
    .core_kbd_dat (core_kbd_dat),
    .core_ms_clk  (core_ms_clk),
    .core_ms_dat  (core_ms_dat),
    .core_kint    (core_kint),
    .core_mint    (core_mint),
    .kint_clr     (kint_clr),
    .kint_out     (kint_out),
    .mint_out     (mint_out)
);

// File: tb/ps2_wake_iso_tb.sv
`timescale 1ns/1ps
module ps2_wake_iso_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_pwr = 1'b1;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] ctrl_rd;
    logic gcr_wr_en = 1'b0;
    logic [7:0] gcr_wr_data = '0;
    logic core_rst;
    logic en_wr = 1'b0;
    logic [3:0] en_wr_data = '0;
    logic gpme_wr = 1'b0;
    logic gpme_wr_data = 1'b0;
    logic sts_clr_wr = 1'b0;
    logic [3:0] sts_clr_data = '0;
    logic [3:0] pme_sts;
    logic pme_out;
    logic kbd_clk_pin = 1'b1, kbd_dat_pin = 1'b1, ms_clk_pin = 1'b1, ms_dat_pin = 1'b1;
    logic core_kbd_clk, core_kbd_dat, core_ms_clk, core_ms_dat;
    logic core_kint = 1'b0, core_mint = 1'b0, kint_clr = 1'b0, mint_clr = 1'b0;
    logic kint_out, mint_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ps2_wake_iso u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d; tick(1); cfg_wr_en = 1'b0;
    endtask

    task automatic wr_gcr(input logic [7:0] d);
        gcr_wr_en = 1'b1; gcr_wr_data = d; tick(1); gcr_wr_en = 1'b0;
    endtask

    task automatic wr_en(input logic [3:0] d);
        en_wr = 1'b1; en_wr_data = d; tick(1); en_wr = 1'b0;
    endtask

    task automatic wr_gpme(input logic d);
        gpme_wr = 1'b1; gpme_wr_data = d; tick(1); gpme_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [3:0] m);
        sts_clr_wr = 1'b1; sts_clr_data = m; tick(1); sts_clr_wr = 1'b0;
    endtask

    // src bits: 0 kint rise, 1 mint rise, 2 kbd data fall, 3 mouse data fall
    task automatic fire(input logic [3:0] src);
        core_kint = src[0]; core_mint = src[1];
        kbd_dat_pin = ~src[2]; ms_dat_pin = ~src[3];
        tick(6);
        core_kint = 1'b0; core_mint = 1'b0;
        kbd_dat_pin = 1'b1; ms_dat_pin = 1'b1;
        tick(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        chk("R11 ctrl", ctrl_rd, 8'h00);
        chk("R11 sts", {4'h0, pme_sts}, 8'h00);
        chk("R11 rst/pme/ints", {4'h0, core_rst, pme_out, kint_out, mint_out}, 8'h00);

        // R1 R2 isolation sweep over every control value and pin pattern
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cv;
            cv = c[3:0];
            wr_ctrl({1'b1, cv, 3'b111});
            chk("R2 readback", ctrl_rd, {1'b0, cv, 3'b000});
            for (int p = 0; p < 16; p++) begin
                logic [3:0] pv;
                logic [3:0] ev;
                pv = p[3:0];
                {ms_clk_pin, ms_dat_pin, kbd_clk_pin, kbd_dat_pin} = pv;
                #1;
                ev[3:2] = cv[3] ? 2'b11 : pv[3:2];
                ev[1:0] = cv[2] ? 2'b11 : pv[1:0];
                chk("R1 R2 core lines", {4'h0, core_ms_clk, core_ms_dat, core_kbd_clk, core_kbd_dat},
                    {4'h0, ev});
                tick(1);
            end
            {ms_clk_pin, ms_dat_pin, kbd_clk_pin, kbd_dat_pin} = 4'hF;
        end
        tick(5);
        clr_sts(4'hF);

        // R4 R5 interrupt shaping for each latch-mode combination
        for (int m = 0; m < 4; m++) begin
            logic km, mm;
            km = m[0]; mm = m[1];
            wr_ctrl({3'b000, mm, km, 3'b000});
            core_kint = 1'b1; core_mint = 1'b1; #1;
            chk("R4 R5 before latch", {6'h0, kint_out, mint_out}, 8'h00);
            tick(1);
            chk("R5 latched live high", {6'h0, kint_out, mint_out}, 8'h03);
            core_kint = 1'b0; core_mint = 1'b0; #1;
            chk("R4 R5 live low", {6'h0, kint_out, mint_out}, {6'h0, km, mm});
            tick(1);
            kint_clr = 1'b1; mint_clr = 1'b1; tick(1);
            kint_clr = 1'b0; mint_clr = 1'b0; #1;
            chk("R5 cleared", {6'h0, kint_out, mint_out}, 8'h00);
            core_kint = 1'b1; core_mint = 1'b1; tick(2);
            kint_clr = 1'b1; mint_clr = 1'b1; tick(1);
            kint_clr = 1'b0; mint_clr = 1'b0; #1;
            chk("R4 live high unlatched", {6'h0, kint_out, mint_out}, 8'h00);
            core_kint = 1'b0; core_mint = 1'b0; tick(2);
        end
        wr_ctrl(8'h00);
        clr_sts(4'hF);

        // R6 each source sets its own bit
        for (int s = 0; s < 4; s++) begin
            fire(4'b0001 << s);
            chk("R6 source bit", {4'h0, pme_sts}, {4'h0, 4'b0001 << s});
            clr_sts(4'hF);
        end

        // R7 standby rail
        main_pwr = 1'b0;
        for (int s = 0; s < 4; s++) begin
            logic [3:0] e;
            e = (s >= 2) ? (4'b0001 << s) : 4'b0000;
            fire(4'b0001 << s);
            chk("R7 standby source", {4'h0, pme_sts}, {4'h0, e});
            clr_sts(4'hF);
        end
        main_pwr = 1'b1;

        // R3 wake path through isolation
        wr_ctrl(8'h60);
        kbd_dat_pin = 1'b0; ms_dat_pin = 1'b0; #1;
        chk("R3 core data blocked", {6'h0, core_kbd_dat, core_ms_dat}, 8'h03);
        tick(6);
        kbd_dat_pin = 1'b1; ms_dat_pin = 1'b1; tick(5);
        chk("R3 edges seen", {4'h0, pme_sts}, 8'h0C);
        wr_ctrl(8'h00);
        clr_sts(4'hF);

        // R8 sticky with wake output disabled
        fire(4'hF);
        tick(50);
        chk("R8 sticky", {4'h0, pme_sts}, 8'h0F);
        chk("R9 gated off", {7'h0, pme_out}, 8'h00);

        // R8 R9 sweep over clear masks, enables and global enable
        for (int mk = 0; mk < 16; mk++) begin
            logic [3:0] mv;
            mv = mk[3:0];
            clr_sts(4'hF);
            chk("R8 all cleared", {4'h0, pme_sts}, 8'h00);
            fire(4'hF);
            clr_sts(mv);
            chk("R8 partial clear", {4'h0, pme_sts}, {4'h0, ~mv});
            for (int g = 0; g < 2; g++) begin
                wr_gpme(g[0]);
                for (int e = 0; e < 16; e++) begin
                    logic [3:0] ev;
                    ev = e[3:0];
                    wr_en(ev);
                    chk("R9 pme", {7'h0, pme_out},
                        {7'h0, g[0] & ((~mv & ev) != 4'h0)});
                end
            end
        end
        wr_gpme(1'b0);
        wr_en(4'h0);

        // R10 core reset bit
        wr_gcr(8'h40);
        chk("R10 set", {7'h0, core_rst}, 8'h01);
        tick(20);
        chk("R10 not self-clearing", {7'h0, core_rst}, 8'h01);
        wr_gcr(8'h00);
        chk("R10 release", {7'h0, core_rst}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule